// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register File

This block holds the software-visible registers of a two-channel bus-master disk DMA controller. A host reaches it through a plain byte-addressed I/O slave port. Every access carries a byte address, a size code and a read or write strobe. Each channel owns an eight-byte window. The window holds a command byte, a status byte and a 32-bit pointer to the descriptor table.

The command/status half accepts single-byte accesses only. The status byte combines three write policies in one byte: some bits are plainly writable, one bit is preserved, and two bits are cleared by writing ones. Completion and error events from the data mover set status bits. Each channel's drive interrupt level is copied into the top bit of that channel's configuration status byte and passed on to a legacy interrupt line. The data mover reads the run and direction controls from dedicated outputs.

Top module: `dual_bm_regfile`

## Requirements
- R1: Channel n occupies bytes n*8 to n*8+7. Within a window, offset 0 is the command byte, offset 2 is the status byte, and offsets 4 to 7 hold the descriptor pointer in little-endian order. Read data appears on `io_rdata` on the clock edge that samples `io_rd`, and channels never disturb each other.
- R2: In offsets 0 to 3, an access with a size code other than 0 is refused. A refused read returns ones across its width (0x0000FFFF for size code 1, 0xFFFFFFFF for size code 2 or 3), and a refused write changes nothing. Size codes: 0 = one byte, 1 = two bytes, 2 or 3 = four bytes.
- R3: Single-byte reads at offsets 1 and 3 return 0xFF. Writes there change no register.
- R4: A status write loads bits 6:5 from the data, keeps bit 0, and clears bit 2 and bit 1 wherever the data bit is 1. Bits 7, 4 and 3 become 0.
- R5: A command write copies data bit 0 into the run control (command bit 0) and into status bit 0, and holds data bit 3 as the direction (command bit 3). Other command bits read as 0. `ch_run` and `ch_dir` show the held bits.
- R6: A `xfer_done` pulse sets status bit 2 and a `dma_err` pulse sets status bit 1. An event wins over a clearing write to the same bit in the same cycle.
- R7: The descriptor pointer takes writes of any size at any offset in 4 to 7, byte lane by byte lane; lanes past offset 7 are dropped. A read returns the pointer shifted right by the offset and masked to the access width. Pointer bits 1:0 always read as 0.
- R8: `cfg_irq_flag[n]`, which is bit 7 of configuration byte 0x70+8*n, equals `drv_irq[n]` one cycle earlier.
- R9: `legacy_irq[n]` carries the same registered level as `cfg_irq_flag[n]`. Index 0 drives interrupt line 14 and index 1 drives line 15.
- R10: A synchronous reset clears the command, status and pointer registers of both channels, both mirror flags, both legacy lines and `io_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| io_addr | input | 4 | byte address (bits above 2 select the channel) |
| io_size | input | 2 | access size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| io_wr | input | 1 | write strobe |
| io_rd | input | 1 | read strobe |
| io_wdata | input | 32 | write data, lane 0 in bits 7:0 |
| io_rdata | output | 32 | registered read data |
| drv_irq | input | 2 | per-channel drive interrupt level |
| xfer_done | input | 2 | per-channel transfer-complete pulse |
| dma_err | input | 2 | per-channel DMA error pulse |
| ch_run | output | 2 | per-channel run control |
| ch_dir | output | 2 | per-channel direction control |
| cfg_irq_flag | output | 2 | mirrored interrupt bit of each configuration status byte |
| legacy_irq | output | 2 | legacy interrupt lines 14 (index 0) and 15 (index 1) |

## Verification
A software status write and a mover event can fall on the same clock edge, and they can target the same bit. The bench provokes this in two ways. It raises `xfer_done` while writing a 1 to status bit 2, and it raises `dma_err` while writing a 1 to status bit 1. It then reads the status byte back and expects the event bit still set (R6). A later write with no event present is expected to clear that same bit, which shows that the clear itself works.

// File: rtl/bmr_pkg.sv
package bmr_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } acc_size_e;

  localparam int WORD_W = 32;

  // ones over the access width
  function automatic logic [WORD_W-1:0] width_mask(input acc_size_e sz);
    case (sz)
      SZ_BYTE: width_mask = 32'h0000_00FF;
      SZ_HALF: width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [2:0] size_bytes(input acc_size_e sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/bm_chan_regs.sv
module bm_chan_regs
  import bmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [2:0]        off,
  input  logic [1:0]        size,
  input  logic [WORD_W-1:0] wdata,
  input  logic              ev_done,
  input  logic              ev_err,
  output logic [WORD_W-1:0] rd_word,
  output logic              run,
  output logic              dir
);

  localparam logic [7:0] ST_RW_MASK  = 8'h60;
  localparam logic [7:0] ST_KEEP     = 8'h01;
  localparam logic [7:0] ST_W1C_MASK = 8'h06;

  acc_size_e  sz;
  logic       is_byte;
  logic       cmd_wr, st_wr, ptr_wr;
  logic [7:0] st_q, st_d;
  logic       run_q, dir_q;
  logic [WORD_W-1:2] ptr_q;
  logic [WORD_W-1:0] ptr_full, ptr_d;

  assign sz      = acc_size_e'(size);
  assign is_byte = (sz == SZ_BYTE);
  assign cmd_wr  = wr && is_byte && (off == 3'd0);
  assign st_wr   = wr && is_byte && (off == 3'd2);
  assign ptr_wr  = wr && off[2];
  assign ptr_full = {ptr_q, 2'b00};

  // status next state: software policy first, events applied last so they win
  always_comb begin
    st_d = st_q;
    if (st_wr)
      st_d = (wdata[7:0] & ST_RW_MASK) | (st_q & ST_KEEP) |
             (st_q & ~wdata[7:0] & ST_W1C_MASK);
    if (cmd_wr)
      st_d[0] = wdata[0];
    if (ev_done)
      st_d[2] = 1'b1;
    if (ev_err)
      st_d[1] = 1'b1;
  end

  // descriptor pointer: lane merge, lanes beyond the window dropped
  always_comb begin
    logic [2:0] pos;
    ptr_d = ptr_full;
    for (int k = 0; k < 4; k++) begin
      pos = {1'b0, off[1:0]} + 3'(k);
      if (ptr_wr && (3'(k) < size_bytes(sz)) && !pos[2])
        ptr_d[{pos[1:0], 3'b000} +: 8] = wdata[k*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      run_q <= 1'b0;
      dir_q <= 1'b0;
      ptr_q <= '0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d[WORD_W-1:2];
      if (cmd_wr) begin
        run_q <= wdata[0];
        dir_q <= wdata[3];
      end
    end
  end

  always_comb begin
    if (off[2])
      rd_word = (ptr_full >> {off[1:0], 3'b000}) & width_mask(sz);
    else if (!is_byte)
      rd_word = width_mask(sz);
    else begin
      case (off[1:0])
        2'd0:    rd_word = {24'h0, 4'h0, dir_q, 2'b00, run_q};
        2'd2:    rd_word = {24'h0, st_q};
        default: rd_word = 32'h0000_00FF;
      endcase
    end
  end

  assign run = run_q;
  assign dir = dir_q;

  p_stat_rsvd_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q[7] == 1'b0) && (st_q[4:3] == 2'b00));

  p_start_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> (st_q[0] == $past(wdata[0])) && (run_q == $past(wdata[0])));

  p_wide_wr_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && !off[2] && !is_byte && !ev_done && !ev_err)
      |=> $stable(st_q) && $stable(run_q) && $stable(dir_q));

  p_done_wins_r6: assert property (@(posedge clk) disable iff (rst)
    ev_done |=> st_q[2]);

  p_err_wins_r6: assert property (@(posedge clk) disable iff (rst)
    ev_err |=> st_q[1]);

endmodule

// File: rtl/bm_irq_mirror.sv
module bm_irq_mirror #(
  parameter int NCHAN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCHAN-1:0] drv_irq,
  output logic [NCHAN-1:0] cfg_flag,
  output logic [NCHAN-1:0] legacy
);

  logic [NCHAN-1:0] flag_q, line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      line_q <= '0;
    end else begin
      flag_q <= drv_irq;
      line_q <= drv_irq;
    end
  end

  assign cfg_flag = flag_q;
  assign legacy   = line_q;

  p_mirror_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flag_q == $past(drv_irq)));

  p_legacy_r9: assert property (@(posedge clk) disable iff (rst)
    line_q == flag_q);

endmodule

// File: rtl/dual_bm_regfile.sv
module dual_bm_regfile
  import bmr_pkg::*;
#(
  parameter int NCHAN = 2,
  localparam int AW = $clog2(NCHAN * 8),
  localparam int CW = AW - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     io_addr,
  input  logic [1:0]        io_size,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [WORD_W-1:0] io_wdata,
  output logic [WORD_W-1:0] io_rdata,
  input  logic [NCHAN-1:0]  drv_irq,
  input  logic [NCHAN-1:0]  xfer_done,
  input  logic [NCHAN-1:0]  dma_err,
  output logic [NCHAN-1:0]  ch_run,
  output logic [NCHAN-1:0]  ch_dir,
  output logic [NCHAN-1:0]  cfg_irq_flag,
  output logic [NCHAN-1:0]  legacy_irq
);

  logic [CW-1:0]     ch_sel;
  logic [WORD_W-1:0] ch_word [NCHAN];
  logic [WORD_W-1:0] rdata_q;

  assign ch_sel = io_addr[AW-1:3];

  for (genvar g = 0; g < NCHAN; g++) begin : g_chan
    bm_chan_regs u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr      (io_wr && (ch_sel == CW'(g))),
      .off     (io_addr[2:0]),
      .size    (io_size),
      .wdata   (io_wdata),
      .ev_done (xfer_done[g]),
      .ev_err  (dma_err[g]),
      .rd_word (ch_word[g]),
      .run     (ch_run[g]),
      .dir     (ch_dir[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (io_rd)
      rdata_q <= ch_word[ch_sel];
  end

  assign io_rdata = rdata_q;

  bm_irq_mirror #(.NCHAN(NCHAN)) u_mirror (
    .clk      (clk),
    .rst      (rst),
    .drv_irq  (drv_irq),
    .cfg_flag (cfg_irq_flag),
    .legacy   (legacy_irq)
  );

  p_wide_rd_r2: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !io_addr[2] && (io_size != 2'd0)) |=> (io_rdata[15:0] == 16'hFFFF));

  p_rd_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata));

endmodule

// File: tb/dual_bm_regfile_test.sv
`timescale 1ns/1ps
module dual_bm_regfile_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  io_addr = '0;
  logic [1:0]  io_size = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic [1:0]  drv_irq = '0, xfer_done = '0, dma_err = '0;
  logic [1:0]  ch_run, ch_dir, cfg_irq_flag, legacy_irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dual_bm_regfile uut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_size(io_size),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .drv_irq(drv_irq), .xfer_done(xfer_done), .dma_err(dma_err),
    .ch_run(ch_run), .ch_dir(ch_dir), .cfg_irq_flag(cfg_irq_flag),
    .legacy_irq(legacy_irq)
  );

  // entry: {is_write, addr[3:0], size[1:0], data[31:0], expect[31:0], req[3:0]}
  localparam int NV = 34;
  localparam logic [74:0] VEC [NV] = '{
    {1'b0, 4'h0, 2'd0, 32'h0,        32'h0000_0000, 4'd10}, // R10 reset cmd
    {1'b1, 4'h0, 2'd0, 32'h09,       32'h0,         4'd5 },
    {1'b0, 4'h0, 2'd0, 32'h0,        32'h0000_0009, 4'd5 }, // R5 run+dir
    {1'b0, 4'h2, 2'd0, 32'h0,        32'h0000_0001, 4'd5 }, // R5 status bit0
    {1'b1, 4'h0, 2'd0, 32'hF7,       32'h0,         4'd5 },
    {1'b0, 4'h0, 2'd0, 32'h0,        32'h0000_0001, 4'd5 }, // R5 other bits 0
    {1'b1, 4'h2, 2'd0, 32'hFF,       32'h0,         4'd4 },
    {1'b0, 4'h2, 2'd0, 32'h0,        32'h0000_0061, 4'd4 }, // R4 mixed policy
    {1'b0, 4'h0, 2'd1, 32'h0,        32'h0000_FFFF, 4'd2 }, // R2 half read
    {1'b0, 4'h2, 2'd2, 32'h0,        32'hFFFF_FFFF, 4'd2 }, // R2 word read
    {1'b1, 4'h2, 2'd1, 32'h0,        32'h0,         4'd2 },
    {1'b0, 4'h2, 2'd0, 32'h0,        32'h0000_0061, 4'd2 }, // R2 wide write dropped
    {1'b0, 4'h1, 2'd0, 32'h0,        32'h0000_00FF, 4'd3 }, // R3
    {1'b0, 4'h3, 2'd0, 32'h0,        32'h0000_00FF, 4'd3 }, // R3
    {1'b1, 4'h3, 2'd0, 32'h0,        32'h0,         4'd3 },
    {1'b1, 4'h1, 2'd0, 32'h0,        32'h0,         4'd3 },
    {1'b0, 4'h2, 2'd0, 32'h0,        32'h0000_0061, 4'd3 }, // R3 status intact
    {1'b0, 4'h0, 2'd0, 32'h0,        32'h0000_0001, 4'd3 }, // R3 cmd intact
    {1'b1, 4'h0, 2'd0, 32'h00,       32'h0,         4'd5 },
    {1'b0, 4'h2, 2'd0, 32'h0,        32'h0000_0060, 4'd5 }, // R5 stop clears bit0
    {1'b1, 4'h4, 2'd2, 32'h1234567B, 32'h0,         4'd7 },
    {1'b0, 4'h4, 2'd2, 32'h0,        32'h1234_5678, 4'd7 }, // R7 low bits 0
    {1'b1, 4'h6, 2'd0, 32'hAA,       32'h0,         4'd7 },
    {1'b0, 4'h4, 2'd2, 32'h0,        32'h12AA_5678, 4'd7 }, // R7 byte lane
    {1'b0, 4'h5, 2'd0, 32'h0,        32'h0000_0056, 4'd7 }, // R7
    {1'b0, 4'h6, 2'd1, 32'h0,        32'h0000_12AA, 4'd7 }, // R7
    {1'b0, 4'h7, 2'd2, 32'h0,        32'h0000_0012, 4'd7 }, // R7 shifted
    {1'b0, 4'hA, 2'd0, 32'h0,        32'h0000_0000, 4'd1 }, // R1 ch1 status
    {1'b0, 4'hC, 2'd2, 32'h0,        32'h0000_0000, 4'd1 }, // R1 ch1 pointer
    {1'b1, 4'h8, 2'd0, 32'h08,       32'h0,         4'd1 },
    {1'b0, 4'h8, 2'd0, 32'h0,        32'h0000_0008, 4'd1 }, // R1 ch1 cmd
    {1'b0, 4'h0, 2'd0, 32'h0,        32'h0000_0000, 4'd1 }, // R1 ch0 cmd untouched
    {1'b0, 4'hA, 2'd0, 32'h0,        32'h0000_0000, 4'd5 }, // R5 ch1 status bit0
    {1'b0, 4'h4, 2'd2, 32'h0,        32'h12AA_5678, 4'd1 }  // R1 ch0 pointer intact
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    io_addr = a; io_size = s; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    io_addr = a; io_size = s; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    // R10: state straight after reset
    check("R10 rdata", io_rdata, 32'h0);
    check("R10 flags", {28'h0, cfg_irq_flag, legacy_irq}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][74])
        do_wr(VEC[i][73:70], VEC[i][69:68], VEC[i][67:36]);
      else begin
        do_rd(VEC[i][73:70], VEC[i][69:68], rv);
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), rv, VEC[i][35:4]);
      end
    end

    // R5: control outputs
    check("R5 run/dir", {28'h0, ch_run, ch_dir}, {28'h0, 2'b00, 2'b10});

    // R6: events set bits, ch0 status is 0x60
    @(negedge clk); xfer_done = 2'b01; dma_err = 2'b01;
    @(negedge clk); xfer_done = 2'b00; dma_err = 2'b00;
    do_rd(4'h2, 2'd0, rv); check("R6 events", rv, 32'h66);
    do_wr(4'h2, 2'd0, 32'h02);
    do_rd(4'h2, 2'd0, rv); check("R4 clear bit1", rv, 32'h04);
    // R6: done collides with clear of bit 2
    @(negedge clk); io_addr = 4'h2; io_size = 2'd0; io_wdata = 32'h04; io_wr = 1'b1; xfer_done = 2'b01;
    @(negedge clk); io_wr = 1'b0; xfer_done = 2'b00;
    do_rd(4'h2, 2'd0, rv); check("R6 done wins", rv, 32'h04);
    do_wr(4'h2, 2'd0, 32'h04);
    do_rd(4'h2, 2'd0, rv); check("R4 clear bit2", rv, 32'h00);
    @(negedge clk); dma_err = 2'b01;
    @(negedge clk); dma_err = 2'b00;
    @(negedge clk); io_addr = 4'h2; io_wdata = 32'h02; io_wr = 1'b1; dma_err = 2'b01;
    @(negedge clk); io_wr = 1'b0; dma_err = 2'b00;
    do_rd(4'h2, 2'd0, rv); check("R6 err wins", rv, 32'h02);

    // R8/R9: interrupt mirror
    @(negedge clk); drv_irq = 2'b10;
    @(negedge clk);
    check("R8 flag high", {30'h0, cfg_irq_flag}, 32'h2);
    check("R9 legacy high", {30'h0, legacy_irq}, 32'h2);
    drv_irq = 2'b01;
    @(negedge clk);
    check("R8 flag swap", {30'h0, cfg_irq_flag}, 32'h1);
    drv_irq = 2'b00;
    @(negedge clk);
    check("R9 legacy low", {30'h0, legacy_irq}, 32'h0);

    // R10: reset mid-run clears everything
    drv_irq = 2'b11;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R10 flags in reset", {28'h0, cfg_irq_flag, legacy_irq}, 32'h0);
    check("R10 ctrl in reset", {28'h0, ch_run, ch_dir}, 32'h0);
    drv_irq = 2'b00;
    @(negedge clk); rst = 1'b0;
    do_rd(4'h4, 2'd2, rv); check("R10 ptr", rv, 32'h0);
    do_rd(4'h2, 2'd0, rv); check("R10 status", rv, 32'h0);
    do_rd(4'h8, 2'd0, rv); check("R10 ch1 cmd", rv, 32'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule